// File: doc/BRIEF.md
# Pipeline Boundary Register with Replay Buffer

This block is the register slice that sits between two stages of a processor pipeline. It carries an instruction word of configurable width together with a valid flag from an upstream stage to a downstream stage. The downstream stage raises `stall_in` to say that it cannot take the slice's output on the coming edge. The slice returns that request to the upstream stage only after one register, as `stall_out`. As a result, the upstream stage has a full clock cycle to react to a stall, and the backward stall path never crosses more than one stage in a cycle.

Because the request reaches the upstream stage one cycle late, the upstream stage delivers one more item after the stall begins. A single shadow register catches that item. When the stall clears, the main register takes its next value from the shadow register rather than from the input, which the upstream stage is still holding for that one cycle. After that, normal flow resumes. An empty slot is marked by a separate valid bit and not by a reserved instruction encoding.

A parameter selects when the shadow register loads. It can load only on the cycle a stall starts, or on every cycle in which the delayed stall is low. The second choice needs simpler enable logic but switches the register more often. Both choices give identical behaviour at the ports.

Top module: `pipe_stall_slice`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_valid` and `stall_out` are 0, whatever the other inputs are.
- R2: `stall_out` equals the value `stall_in` had on the previous clock edge.
- R3: On an edge where `stall_in` is 1, `out_valid` and `out_data` keep their values.
- R4: On an edge where `stall_in` and `stall_out` are both 0, `out_valid` takes `in_valid`, and `out_data` takes `in_data` when `in_valid` is 1.
- R5: On an edge where `stall_in` is 1 and `stall_out` is 0, the slice accepts the presented input (valid flag and word) into its shadow register. Nothing is lost, even though the main register is holding.
- R6: On an edge where `stall_in` is 0 and `stall_out` is 1, the main register takes the content of the shadow register, and `in_valid` and `in_data` have no effect.
- R7: If the shadow register holds no valid item when it is replayed, `out_valid` becomes 0. A stale word is never presented as valid.
- R8: An item counts as accepted when `in_valid` is 1 and `stall_out` is 0 at an edge. An item counts as delivered when `out_valid` is 1 and `stall_in` is 0 at an edge. For any pattern of `stall_in`, every accepted item is delivered exactly once and in acceptance order, and nothing else is delivered.
- R9: The two shadow-load variants (load on stall onset only, or load on every open cycle) produce identical port outputs for identical inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Upstream item present |
| in_data | input | DATA_W | Upstream instruction word |
| stall_in | input | 1 | Downstream cannot take the output on this edge |
| out_valid | output | 1 | Output item present |
| out_data | output | DATA_W | Output instruction word |
| stall_out | output | 1 | Registered stall request toward the upstream stage |

## Verification
Directed sequences cover the following cases:
- A single-cycle stall pulse, which shows that the item caught at the stall onset is replayed ahead of newer input.
- A stall that starts with no valid input, which shows that an empty shadow slot empties the main register.
- A long stall during which garbage is driven, which shows that the input is ignored while `stall_out` is high.

Random phases with sparse, dense and balanced stall densities, together with random upstream valids, are checked against a reference queue. This separates lost, duplicated and reordered items. A second instance uses the other shadow-load variant and is compared with the first every cycle.

// File: rtl/boundary_pkg.sv
package boundary_pkg;
   // When the shadow register is allowed to load
   typedef enum logic {
      SHADOW_ON_ONSET = 1'b0,  // only on the cycle a stall begins
      SHADOW_WHILE_OPEN = 1'b1 // every cycle the delayed stall is low
   } shadow_mode_e;
endpackage

// File: rtl/stall_delay_flop.sv
module stall_delay_flop (
   input  logic clk,
   input  logic rst_n,
   input  logic stall_in,
   output logic stall_q
);
   logic live_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stall_q <= 1'b0;
         live_q  <= 1'b0;
      end else begin
         stall_q <= stall_in;
         live_q  <= 1'b1;
      end
   end

   // R2
   stall_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      live_q |=> stall_q == $past(stall_in));
endmodule

// File: rtl/shadow_buffer.sv
module shadow_buffer
   import boundary_pkg::*;
#(
   parameter int unsigned  DATA_W = 32,
   parameter shadow_mode_e MODE   = SHADOW_ON_ONSET
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stall_in,
   input  logic              stall_q,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              buf_valid,
   output logic [DATA_W-1:0] buf_data
);
   logic load_en;
   logic replay;

   generate
      if (MODE == SHADOW_WHILE_OPEN) begin : g_open
         assign load_en = !stall_q;
      end else begin : g_onset
         assign load_en = stall_in && !stall_q;
      end
   endgenerate

   assign replay = stall_q && !stall_in;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_valid <= 1'b0;
      end else if (load_en) begin
         buf_valid <= in_valid;
      end else if (replay) begin
         buf_valid <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (load_en && in_valid) begin
         buf_data <= in_data;
      end
   end

   // R5
   onset_catch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_in && !stall_q) |=> buf_valid == $past(in_valid));

   // R5
   onset_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_in && !stall_q && in_valid) |=> buf_data == $past(in_data));

   // R6
   replay_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_q && !stall_in) |=> !buf_valid);
endmodule

// File: rtl/main_stage.sv
module main_stage #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stall_in,
   input  logic              stall_q,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              buf_valid,
   input  logic [DATA_W-1:0] buf_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);
   logic              src_valid;
   logic [DATA_W-1:0] src_data;

   // source select: live input while open, shadow copy on the release cycle
   always_comb begin
      if (stall_q) begin
         src_valid = buf_valid;
         src_data  = buf_data;
      end else begin
         src_valid = in_valid;
         src_data  = in_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
      end else if (!stall_in) begin
         out_valid <= src_valid;
      end
   end

   always_ff @(posedge clk) begin
      if (!stall_in && src_valid) begin
         out_data <= src_data;
      end
   end

   // R3
   hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall_in |=> ($stable(out_valid) && $stable(out_data)));

   // R4
   pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall_in && !stall_q) |=> out_valid == $past(in_valid));

   // R6
   replay_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall_in && stall_q && buf_valid) |=> (out_valid && out_data == $past(buf_data)));

   // R7
   empty_replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall_in && stall_q && !buf_valid) |=> !out_valid);
endmodule

// File: rtl/pipe_stall_slice.sv
module pipe_stall_slice
   import boundary_pkg::*;
#(
   parameter int unsigned  DATA_W      = 32,
   parameter shadow_mode_e SHADOW_MODE = SHADOW_ON_ONSET
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              stall_in,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              stall_out
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("pipe_stall_slice: DATA_W must be at least 1");
      end
   endgenerate

   logic              stall_q;
   logic              buf_valid;
   logic [DATA_W-1:0] buf_data;

   stall_delay_flop u_delay (
      .clk      (clk),
      .rst_n    (rst_n),
      .stall_in (stall_in),
      .stall_q  (stall_q)
   );

   shadow_buffer #(
      .DATA_W (DATA_W),
      .MODE   (SHADOW_MODE)
   ) u_shadow (
      .clk       (clk),
      .rst_n     (rst_n),
      .stall_in  (stall_in),
      .stall_q   (stall_q),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .buf_valid (buf_valid),
      .buf_data  (buf_data)
   );

   main_stage #(
      .DATA_W (DATA_W)
   ) u_main (
      .clk       (clk),
      .rst_n     (rst_n),
      .stall_in  (stall_in),
      .stall_q   (stall_q),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .buf_valid (buf_valid),
      .buf_data  (buf_data),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   assign stall_out = stall_q;

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && !stall_out));
endmodule

// File: tb/pipe_stall_slice_bench.sv
`timescale 1ns/1ps
module pipe_stall_slice_bench;
   import boundary_pkg::*;

   localparam int W = 32;
   localparam int QN = 1024;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [W-1:0] in_data = '0;
   logic         stall_in = 1'b0;
   logic         out_valid, out_valid_b;
   logic [W-1:0] out_data, out_data_b;
   logic         stall_out, stall_out_b;

   int total = 0;
   int bad = 0;
   logic [W-1:0] q [QN];
   int qh = 0;
   int qt = 0;
   int seq = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   pipe_stall_slice #(.DATA_W(W), .SHADOW_MODE(SHADOW_ON_ONSET)) u_pipe_stall_slice (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .stall_in(stall_in), .out_valid(out_valid), .out_data(out_data),
      .stall_out(stall_out));

   pipe_stall_slice #(.DATA_W(W), .SHADOW_MODE(SHADOW_WHILE_OPEN)) u_pipe_stall_slice_alt (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .stall_in(stall_in), .out_valid(out_valid_b), .out_data(out_data_b),
      .stall_out(stall_out_b));

   function automatic logic [W-1:0] item_word(input int n);
      return (W'(n) * 32'h9E37_79B9) ^ 32'h0F0F_1234;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                      input logic [W-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc(input logic v, input logic [W-1:0] d, input logic s);
      logic         open_before;
      logic         pv;
      logic [W-1:0] pd;
      @(negedge clk);
      in_valid = v;
      in_data  = d;
      stall_in = s;
      open_before = !stall_out;
      if (rst_n && open_before && v) begin
         q[qt % QN] = d;
         qt++;
      end
      if (rst_n && !s && out_valid) begin
         if (qh == qt) begin
            chk(1'b0, "R8 delivery with nothing accepted", out_data, '0);
         end else begin
            chk(out_data == q[qh % QN], "R8 order", out_data, q[qh % QN]);
            qh++;
         end
      end
      pv = out_valid;
      pd = out_data;
      @(posedge clk);
      #1;
      if (rst_n) begin
         chk(stall_out == s, "R2 stall_out", W'(stall_out), W'(s));
         if (s) begin
            chk(out_valid == pv && (!pv || out_data == pd), "R3 hold",
                out_data, pd);
         end else if (open_before) begin
            chk(out_valid == v && (!v || out_data == d), "R4 pass",
                {out_valid, out_data[W-2:0]}, {v, d[W-2:0]});
         end
         chk(out_valid == out_valid_b && stall_out == stall_out_b &&
             (!out_valid || out_data == out_data_b), "R9 variants",
             out_data_b, out_data);
      end
   endtask

   task automatic next_item(input logic v, input logic s);
      logic acc;
      acc = !stall_out;
      if (acc && v) begin
         cyc(1'b1, item_word(seq), s);
         seq++;
      end else begin
         cyc(v, $urandom, s);
      end
   endtask

   task automatic summary;
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(4 * 150000);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
   end

   initial begin
      logic [W-1:0] a_word;
      logic [W-1:0] b_word;
      void'($urandom(32'd20240517));
      // reset with busy inputs
      rst_n = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_data = $urandom;
         stall_in = 1'b1;
         @(posedge clk);
         #1;
         chk(!out_valid && !stall_out, "R1 during reset",
             {30'd0, out_valid, stall_out}, '0);
      end
      @(negedge clk);
      rst_n = 1'b1;
      in_valid = 1'b0;
      stall_in = 1'b0;
      @(posedge clk);
      #1;
      chk(!out_valid && !stall_out, "R1 after release",
          {30'd0, out_valid, stall_out}, '0);

      // R5/R6: single-cycle stall pulse, caught item replayed first
      a_word = item_word(seq);
      next_item(1'b1, 1'b0);
      b_word = item_word(seq);
      next_item(1'b1, 1'b1);
      chk(out_data == a_word, "R5 main held at onset", out_data, a_word);
      cyc(1'b1, 32'hDEAD_BEEF, 1'b0);
      chk(out_valid && out_data == b_word, "R6 replay of caught item",
          out_data, b_word);
      next_item(1'b1, 1'b0);

      // R6: long stall with garbage ignored
      next_item(1'b1, 1'b1);
      for (int i = 0; i < 6; i++) cyc(1'b1, $urandom, 1'b1);
      cyc(1'b1, 32'hBAD0_0BAD, 1'b0);
      chk(out_data != 32'hBAD0_0BAD, "R6 ignored input", out_data, '0);
      next_item(1'b0, 1'b0);

      // R7: stall begins with no valid input
      next_item(1'b1, 1'b0);
      cyc(1'b0, 32'h1111_1111, 1'b1);
      cyc(1'b1, 32'h2222_2222, 1'b1);
      cyc(1'b1, 32'h3333_3333, 1'b0);
      chk(!out_valid, "R7 empty replay", W'(out_valid), '0);
      next_item(1'b0, 1'b0);

      // random phases: sparse, dense, balanced stalls
      for (int ph = 0; ph < 3; ph++) begin
         for (int i = 0; i < 3000; i++) begin
            logic s;
            logic v;
            int r;
            r = $urandom_range(99);
            s = (ph == 0) ? (r < 20) : (ph == 1) ? (r < 75) : (r < 50);
            v = ($urandom_range(99) < 70);
            next_item(v, s);
         end
      end

      // drain
      for (int i = 0; i < 6; i++) cyc(1'b0, $urandom, 1'b0);
      chk(qh == qt, "R8 all delivered", W'(qh), W'(qt));
      summary();
   end
endmodule